// File: doc/BRIEF.md
# Serial Character Receiver with Break and Framing Recovery

This block turns an asynchronous serial line into characters. A clock enable that pulses sixteen times per bit period times it. It looks for a falling edge on the idle line and checks the start bit at its centre. It then collects 5 to 8 data bits, least significant first, and an optional parity bit. Last, it checks the first stop bit. Each finished character goes to a downstream buffer through a one-cycle write strobe. The strobe carries three tags: parity error, framing error and break.

Two recovery paths decide what happens after a bad frame. A low stop bit is taken as the start bit of the next character, so a stream that lost one stop bit stays in step. A line that stays low for a whole frame gives one zero character tagged as a break. The receiver then stays deaf until the line has been high for two samples in a row and a fresh start bit arrives.

Top module: `uart_rx_brk`

## Requirements
- R1: After synchronous reset the write strobe is low and the character outputs are zero, and no strobe occurs while the line stays high.
- R2: A start bit that reads high at its centre sample is a false start. The receiver goes back to hunting and delivers nothing.
- R3: Data bits are sampled at bit centre and assembled least significant bit first. The word length code `cfg_wlen` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits above the word length read as zero.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity, counting the ones in data plus parity. A mismatch sets `rx_perr_o`. With parity disabled no parity bit is expected and `rx_perr_o` is 0.
- R5: A first stop bit sampled low sets `rx_ferr_o` on that character.
- R6: Each character gives exactly one write strobe, one clock cycle wide. It is issued at the centre sample of the first stop bit.
- R7: With `cfg_two_stop`=1 the receiver waits out the second stop bit before it hunts for the next start. Frames sent back to back with two stop bits are all received correctly.
- R8: A break is a frame in which start, every data bit, the parity bit (if enabled) and the stop bit all read low. It delivers data 0x00 with `rx_brk_o`=1, `rx_ferr_o`=1 and `rx_perr_o`=0.
- R9: A break delivers only one character, however long the line stays low.
- R10: After a break, reception resumes only after two consecutive high samples followed by a valid start bit. One high sample between low stretches does not rearm the receiver.
- R11: After a framing error that is not a break, the low stop level is taken as the next start bit. If the next sample is also low, the following bit periods are received as that character's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample enable, sixteen pulses per bit |
| rx_i | input | 1 | Serial line, high when idle |
| cfg_wlen | input | 2 | Word length code: 0..3 gives 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rx_wr_o | output | 1 | One-cycle write strobe to the buffer |
| rx_data_o | output | 8 | Received character, zero-extended |
| rx_perr_o | output | 1 | Parity error tag |
| rx_ferr_o | output | 1 | Framing error tag |
| rx_brk_o | output | 1 | Break tag |

## Verification
Clean frames at every word length, with odd and even bit patterns, separate the word-length decoding from the bit ordering. Parity frames with the parity bit right and with it inverted, under both senses, separate a polarity mistake from a missed check. A frame with a low stop bit followed straight away by the next character's data bits shows whether the resync path aligns to the bad stop level. A long low line followed by a single high sample and then a low stretch shows whether the break gives exactly one character and whether rearming waits for a real marking period. A short low glitch before a valid frame exercises the false-start check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2,
        ST_RESYNC,
        ST_BRKW
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;

    // parity check: even wants xor of all ones == 0, odd wants == 1
    function automatic logic parity_bad(logic acc, logic pbit, logic odd);
        return acc ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], d_i};
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rx_sample_timer.sv
module rx_sample_timer #(
    parameter int OSR = 16,
    localparam int CW = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          at_mid,
    output logic          at_end
);
    localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign at_mid = tick && (cnt == MID);
    assign at_end = tick && (cnt == LAST);
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OSR          = 16,
    parameter int MARK_SAMPLES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_en,
    input  logic       rx_i,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    output logic       rx_wr_o,
    output logic [7:0] rx_data_o,
    output logic       rx_perr_o,
    output logic       rx_ferr_o,
    output logic       rx_brk_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MARK_LAST = CW'(MARK_SAMPLES - 1);

    logic          rxs;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic [CW-1:0] tcnt;
    logic          at_mid, at_end;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(rx_i), .q_o(rxs)
    );

    rx_sample_timer #(.OSR(OSR)) u_tmr (
        .clk(clk), .rst(rst), .tick(sample_en),
        .load(tmr_load), .load_val(tmr_val),
        .cnt(tcnt), .at_mid(at_mid), .at_end(at_end)
    );

    rx_state_e  st_q, st_d;
    logic [2:0] bit_q, bit_d;
    logic [7:0] sh_q, sh_d;
    logic       par_q, par_d;
    logic       zero_q, zero_d;
    logic       perr_q, perr_d;
    logic       wr_q, wr_d;
    rx_char_t   out_q, out_d;
    logic [2:0] last_bit;

    assign last_bit = 3'(cfg_wlen) + 3'd4;

    always_comb begin
        st_d     = st_q;
        bit_d    = bit_q;
        sh_d     = sh_q;
        par_d    = par_q;
        zero_d   = zero_q;
        perr_d   = perr_q;
        wr_d     = 1'b0;
        out_d    = out_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_IDLE: if (sample_en && !rxs) begin
                st_d     = ST_START;
                tmr_load = 1'b1;
                tmr_val  = CW'(1);
            end
            ST_START: if (at_mid) begin
                if (rxs) begin
                    st_d = ST_IDLE;
                end else begin
                    st_d     = ST_DATA;
                    tmr_load = 1'b1;
                    bit_d    = '0;
                    sh_d     = '0;
                    par_d    = 1'b0;
                    zero_d   = 1'b1;
                    perr_d   = 1'b0;
                end
            end
            ST_DATA: if (at_end) begin
                sh_d[bit_q] = rxs;
                par_d       = par_q ^ rxs;
                if (rxs) zero_d = 1'b0;
                tmr_load    = 1'b1;
                if (bit_q == last_bit) st_d = cfg_par_en ? ST_PAR : ST_STOP;
                else                   bit_d = bit_q + 3'd1;
            end
            ST_PAR: if (at_end) begin
                perr_d   = parity_bad(par_q, rxs, cfg_par_odd);
                if (rxs) zero_d = 1'b0;
                tmr_load = 1'b1;
                st_d     = ST_STOP;
            end
            ST_STOP: if (at_end) begin
                tmr_load = 1'b1;
                wr_d     = 1'b1;
                if (rxs) begin
                    out_d = '{data: sh_q, perr: perr_q, ferr: 1'b0, brk: 1'b0};
                    st_d  = cfg_two_stop ? ST_STOP2 : ST_IDLE;
                end else if (zero_q) begin
                    out_d = '{data: 8'h00, perr: 1'b0, ferr: 1'b1, brk: 1'b1};
                    st_d  = ST_BRKW;
                end else begin
                    out_d = '{data: sh_q, perr: perr_q, ferr: 1'b1, brk: 1'b0};
                    st_d  = ST_RESYNC;
                end
            end
            ST_STOP2: if (at_end) st_d = ST_IDLE;
            ST_RESYNC: if (sample_en) begin
                if (rxs) begin
                    st_d = ST_IDLE;
                end else begin
                    st_d     = ST_DATA;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(1);
                    bit_d    = '0;
                    sh_d     = '0;
                    par_d    = 1'b0;
                    zero_d   = 1'b1;
                    perr_d   = 1'b0;
                end
            end
            ST_BRKW: if (sample_en) begin
                if (!rxs)                   tmr_load = 1'b1;
                else if (tcnt == MARK_LAST) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            bit_q  <= '0;
            sh_q   <= '0;
            par_q  <= 1'b0;
            zero_q <= 1'b0;
            perr_q <= 1'b0;
            wr_q   <= 1'b0;
            out_q  <= '0;
        end else begin
            st_q   <= st_d;
            bit_q  <= bit_d;
            sh_q   <= sh_d;
            par_q  <= par_d;
            zero_q <= zero_d;
            perr_q <= perr_d;
            wr_q   <= wr_d;
            out_q  <= out_d;
        end
    end

    assign rx_wr_o   = wr_q;
    assign rx_data_o = out_q.data;
    assign rx_perr_o = out_q.perr;
    assign rx_ferr_o = out_q.ferr;
    assign rx_brk_o  = out_q.brk;

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_wr_o |=> !rx_wr_o); // R6

    AST_WR_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_wr_o) |-> $past(st_q == ST_STOP && at_end)); // R6

    AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_START && at_mid && rxs) |=> st_q == ST_IDLE); // R2

    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rx_wr_o && rx_brk_o) |-> (rx_data_o == 8'h00 && rx_ferr_o && !rx_perr_o)); // R8

    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BRKW && sample_en && !rxs) |=> st_q == ST_BRKW); // R10

    AST_BRK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BRKW) |-> !wr_d); // R9

    AST_RESYNC_FROM_FERR: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_RESYNC) |-> (rx_wr_o && rx_ferr_o && !rx_brk_o)); // R11

    AST_PERR_NO_PARITY: assert property (@(posedge clk) disable iff (rst)
        (rx_wr_o && !rx_brk_o && !$past(cfg_par_en)) |-> !rx_perr_o); // R4
endmodule

// File: tb/sim_uart_rx_brk.sv
module sim_uart_rx_brk;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx  = 1'b1;
    logic [1:0] wlen = 2'd3;
    logic       pen = 1'b0, podd = 1'b0, two = 1'b0;
    logic       wr, perr, ferr, brk;
    logic [7:0] data;
    logic       se;
    int         tdiv = 0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    assign se = (tdiv == 0);

    uart_rx_brk u0 (
        .clk(clk), .rst(rst), .sample_en(se), .rx_i(rx),
        .cfg_wlen(wlen), .cfg_par_en(pen), .cfg_par_odd(podd), .cfg_two_stop(two),
        .rx_wr_o(wr), .rx_data_o(data), .rx_perr_o(perr), .rx_ferr_o(ferr), .rx_brk_o(brk)
    );

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        logic       bk;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    logic prev_wr = 1'b0;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic hold(input logic v, input int nt);
        int k;
        rx = v;
        k = 0;
        while (k < nt) begin
            @(negedge clk);
            if (se) k++;
        end
    endtask

    task automatic push(input logic [7:0] d, input logic pe, input logic fe,
                        input logic bk, input string tag);
        exp_t e;
        e.d = d; e.pe = pe; e.fe = fe; e.bk = bk; e.tag = tag;
        q.push_back(e);
    endtask

    function automatic logic par_of(input logic [7:0] d, input int wl, input logic odd);
        logic p = odd;
        for (int i = 0; i < wl; i++) p ^= d[i];
        return p;
    endfunction

    task automatic send_bits(input logic [7:0] d, input int wl);
        for (int i = 0; i < wl; i++) hold(d[i], 16);
    endtask

    // driver: one frame, expected item pushed to the scoreboard first
    task automatic frame(input logic [7:0] d, input int wl, input logic p_en,
                         input logic p_odd, input logic two_s, input logic flip,
                         input string tag);
        logic [7:0] m;
        m    = d & 8'((1 << wl) - 1);
        wlen = 2'(wl - 5);
        pen  = p_en; podd = p_odd; two = two_s;
        push(m, p_en & flip, 1'b0, 1'b0, tag);
        hold(1'b0, 16);
        send_bits(m, wl);
        if (p_en) hold(par_of(m, wl, p_odd) ^ flip, 16);
        hold(1'b1, two_s ? 32 : 16);
        hold(1'b1, 16);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && wr) begin
            checks++;
            if (prev_wr) begin
                fails++;
                $display("FAIL R6 strobe width: actual >1 cycle expected 1 cycle");
            end
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected strobe: actual data=%h pe=%b fe=%b bk=%b expected none",
                         data, perr, ferr, brk);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (data !== e.d || perr !== e.pe || ferr !== e.fe || brk !== e.bk) begin
                    fails++;
                    $display("FAIL %s: actual data=%h pe=%b fe=%b bk=%b expected data=%h pe=%b fe=%b bk=%b",
                             e.tag, data, perr, ferr, brk, e.d, e.pe, e.fe, e.bk);
                end
            end
        end
        prev_wr = wr;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        hold(1'b1, 20);
        // R1 reset state and quiet idle line
        checks++;
        if (wr !== 1'b0 || data !== 8'h00 || brk !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual wr=%b data=%h brk=%b expected wr=0 data=00 brk=0", wr, data, brk);
        end

        // R3 word lengths, LSB first
        frame(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 8N1");
        frame(8'h1B, 5, 1'b0, 1'b0, 1'b0, 1'b0, "R3 5N1");
        frame(8'h2D, 6, 1'b0, 1'b0, 1'b0, 1'b0, "R3 6N1");
        frame(8'hFF, 7, 1'b0, 1'b0, 1'b0, 1'b0, "R3 7N1 masked");
        // R4 parity senses, good and bad
        frame(8'h55, 7, 1'b1, 1'b0, 1'b0, 1'b0, "R4 7E1 ok");
        frame(8'h81, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R4 8O1 ok");
        frame(8'h37, 8, 1'b1, 1'b0, 1'b0, 1'b1, "R4 8E1 bad");
        frame(8'h0E, 5, 1'b1, 1'b1, 1'b0, 1'b1, "R4 5O1 bad");
        // R7 two stop bits back to back
        frame(8'h3C, 8, 1'b0, 1'b0, 1'b1, 1'b0, "R7 first");
        frame(8'hC3, 8, 1'b0, 1'b0, 1'b1, 1'b0, "R7 second");

        // R5 and R11: low stop taken as next start bit
        wlen = 2'd3; pen = 1'b0; two = 1'b0;
        push(8'h96, 1'b0, 1'b1, 1'b0, "R5 framing");
        push(8'h4E, 1'b0, 1'b0, 1'b0, "R11 resync char");
        hold(1'b0, 16);
        send_bits(8'h96, 8);
        hold(1'b0, 16);
        send_bits(8'h4E, 8);
        hold(1'b1, 32);

        // R8 and R9: long break gives one zero char
        push(8'h00, 1'b0, 1'b1, 1'b1, "R8 break");
        hold(1'b0, 16 * 24);
        // R10: a single high sample must not rearm
        hold(1'b1, 1);
        hold(1'b0, 40);
        hold(1'b1, 32);
        frame(8'h77, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R10 after rearm");

        // R2 false start glitch then a valid frame
        hold(1'b0, 4);
        hold(1'b1, 32);
        frame(8'hE1, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R2 after glitch");

        hold(1'b1, 40);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R6 missing strobes: actual %0d pending expected 0", q.size());
        end
        summary();
    end
endmodule